// File: doc/BRIEF.md
# Critical Stream Gap and Length Policer

This block polices critical traffic one stream at a time. Each frame arrives with a stream index, its length in bytes, a critical flag and the current value of a free-running microsecond counter. The block checks the frame against that stream's configured rules and returns a verdict one cycle later. A frame is dropped if it is longer than the stream's limit. It is also dropped if it comes too soon after the last frame of that stream that was accepted. The verdict carries the stream's forwarding share index and its time-triggered flag, so a downstream forwarding stage can use them.

Each stream has a bandwidth allocation gap, counted in 100 µs units, and a jitter allowance, counted in 10 µs units. The smallest spacing allowed between accepted frames is `bag*100 - jitter*10` µs. The block checks this spacing with modular subtraction on the timestamp, so the time counter may wrap. A configuration write fills one stream entry. The write is rejected when the jitter time exceeds the gap time or when the length limit is above the largest legal frame. After an accepted write, the stream has no history, so its next critical frame passes the gap check.

Top module: `crit_gap_policer`

## Requirements
- R1: Each cycle with `frm_vld_i` high gives one cycle of `vrd_vld_o` high on the next clock. `vrd_acc_o` is high only together with `vrd_vld_o`. After reset, `vrd_vld_o`, `vrd_acc_o` and `cfg_err_o` are low.
- R2: A configuration write is accepted only if `cfg_jit_i*10 <= cfg_bag_i*100` and `cfg_maxlen_i <= 2043`. A write that breaks either rule leaves the table unchanged and drives `cfg_err_o` high for the single cycle after the write. An accepted write leaves `cfg_err_o` low.
- R3: The first critical frame to a stream after an accepted configuration write passes the gap check, whatever the time value.
- R4: A critical frame is dropped if `now_us_i - last_accept` is less than `bag*100 - jitter*10`. It is accepted if that difference is equal to or greater than the gap. `last_accept` is the time of the stream's last accepted critical frame.
- R5: A critical frame is dropped if `frm_len_i` is greater than the stream's length limit. A frame whose length equals the limit is accepted. The length counts both MAC addresses, the EtherType and the FCS, which is 18 bytes of overhead. A critical frame longer than 2043 bytes is always dropped.
- R6: A dropped frame does not change the stream's last-accept time.
- R7: The time difference is taken modulo 2^32, so a counter that wraps between two frames gives the true elapsed time.
- R8: A critical frame to a stream that has never had an accepted configuration write is dropped.
- R9: A frame with `frm_crit_i` low is accepted without any check and does not change the stream's state.
- R10: `vrd_share_o` and `vrd_tt_o` give the share index and the time-triggered flag configured for the frame's stream. They are zero for a stream that has not been configured.
- R11: Streams are independent. A frame accepted on one stream does not change the gap check of any other stream.
- R12: If a configuration write and a frame target the same stream in the same cycle, the frame is judged against the entry as it was before the write, and the write sets the entry's final state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 4 | Stream index to configure |
| cfg_tt_i | input | 1 | Time-triggered flag (1) or rate-constrained (0) |
| cfg_maxlen_i | input | 12 | Maximum frame length in bytes, at most 2043 |
| cfg_share_i | input | 4 | Forwarding share index |
| cfg_bag_i | input | 8 | Allocation gap in 100 µs units |
| cfg_jit_i | input | 12 | Jitter allowance in 10 µs units |
| cfg_err_o | output | 1 | One-cycle pulse after a rejected write |
| frm_vld_i | input | 1 | Frame descriptor valid |
| frm_idx_i | input | 4 | Stream index of the frame |
| frm_len_i | input | 12 | Frame length in bytes |
| frm_crit_i | input | 1 | Frame belongs to critical traffic |
| now_us_i | input | 32 | Free-running microsecond counter |
| vrd_vld_o | output | 1 | Verdict valid |
| vrd_acc_o | output | 1 | 1 means accept, 0 means drop |
| vrd_share_o | output | 4 | Share index of the frame's stream |
| vrd_tt_o | output | 1 | Time-triggered flag of the frame's stream |

## Verification
A wrong last-accept time shows up at the verdict of the next critical frame on that stream. In the cycle after that frame, a drop appears where an accept was due, or the reverse. This is why the tests probe the gap boundary one microsecond on each side, right after a drop. A corrupted gap or length limit, or an entry written by a rejected configuration, also shows up in the first verdict that depends on it. The tests cover a wrapped counter, a jitter equal to the gap, and writes on one stream followed by frames on another, so that state which leaks between streams shows up at the verdict.

// File: rtl/crit_pol_pkg.sv
package crit_pol_pkg;
  localparam int unsigned LEN_W       = 12;
  localparam int unsigned SHARE_W     = 4;
  localparam int unsigned GAP_W       = 16;
  localparam int unsigned MAX_LEN     = 2043;
  localparam int unsigned BAG_UNIT_US = 100;
  localparam int unsigned JIT_UNIT_US = 10;

  typedef struct packed {
    logic               tt;
    logic [LEN_W-1:0]   maxlen;
    logic [SHARE_W-1:0] share;
    logic [GAP_W-1:0]   gap_us;
  } crit_entry_t;
endpackage

// File: rtl/crit_pol_cfg_chk.sv
module crit_pol_cfg_chk
  import crit_pol_pkg::*;
#(
  parameter int unsigned BAG_W = 8,
  parameter int unsigned JIT_W = 12
) (
  input  logic               tt_i,
  input  logic [LEN_W-1:0]   maxlen_i,
  input  logic [SHARE_W-1:0] share_i,
  input  logic [BAG_W-1:0]   bag_i,
  input  logic [JIT_W-1:0]   jit_i,
  output logic               ok_o,
  output crit_entry_t        entry_o
);
  logic [31:0] bag_us, jit_us, gap_full;

  always_comb begin
    bag_us   = 32'(bag_i) * 32'(BAG_UNIT_US);
    jit_us   = 32'(jit_i) * 32'(JIT_UNIT_US);
    gap_full = bag_us - jit_us;
    ok_o     = (jit_us <= bag_us) && (32'(maxlen_i) <= 32'(MAX_LEN));
    entry_o.tt     = tt_i;
    entry_o.maxlen = maxlen_i;
    entry_o.share  = share_i;
    entry_o.gap_us = gap_full[GAP_W-1:0];
  end
endmodule

// File: rtl/crit_pol_table.sv
module crit_pol_table
  import crit_pol_pkg::*;
#(
  parameter int unsigned N_STREAMS = 16,
  parameter int unsigned TS_W      = 32,
  localparam int unsigned IDX_W    = $clog2(N_STREAMS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  crit_entry_t      wr_entry_i,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [TS_W-1:0]  upd_ts_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output crit_entry_t      rd_entry_o,
  output logic             rd_cfgd_o,
  output logic             rd_seen_o,
  output logic [TS_W-1:0]  rd_last_o
);
  crit_entry_t           ent_q  [N_STREAMS];
  logic [N_STREAMS-1:0]  cfgd_q, seen_q;
  logic [TS_W-1:0]       last_q [N_STREAMS];

  for (genvar g = 0; g < N_STREAMS; g++) begin : g_ent
    logic wr_hit, upd_hit;
    assign wr_hit  = wr_en_i  && (wr_idx_i  == IDX_W'(g));
    assign upd_hit = upd_en_i && (upd_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g]  <= '0;
        cfgd_q[g] <= 1'b0;
        seen_q[g] <= 1'b0;
        last_q[g] <= '0;
      end else if (wr_hit) begin
        // write wins over a same-cycle update and clears history
        ent_q[g]  <= wr_entry_i;
        cfgd_q[g] <= 1'b1;
        seen_q[g] <= 1'b0;
      end else if (upd_hit) begin
        seen_q[g] <= 1'b1;
        last_q[g] <= upd_ts_i;
      end
    end
  end

  assign rd_entry_o = ent_q[rd_idx_i];
  assign rd_cfgd_o  = cfgd_q[rd_idx_i];
  assign rd_seen_o  = seen_q[rd_idx_i];
  assign rd_last_o  = last_q[rd_idx_i];
endmodule

// File: rtl/crit_pol_judge.sv
module crit_pol_judge
  import crit_pol_pkg::*;
#(
  parameter int unsigned TS_W = 32
) (
  input  logic             crit_i,
  input  logic [LEN_W-1:0] len_i,
  input  crit_entry_t      entry_i,
  input  logic             cfgd_i,
  input  logic             seen_i,
  input  logic [TS_W-1:0]  last_i,
  input  logic [TS_W-1:0]  now_i,
  output logic             acc_o,
  output logic             upd_o
);
  logic [TS_W-1:0] elapsed;
  logic            gap_ok, len_ok;

  always_comb begin
    elapsed = now_i - last_i;  // modular, tolerates wrap
    gap_ok  = !seen_i || (elapsed >= TS_W'(entry_i.gap_us));
    len_ok  = len_i <= entry_i.maxlen;
    acc_o   = !crit_i || (cfgd_i && len_ok && gap_ok);
    upd_o   = crit_i && acc_o;
  end
endmodule

// File: rtl/crit_gap_policer.sv
module crit_gap_policer
  import crit_pol_pkg::*;
#(
  parameter int unsigned N_STREAMS = 16,
  parameter int unsigned TS_W      = 32,
  parameter int unsigned BAG_W     = 8,
  parameter int unsigned JIT_W     = 12,
  localparam int unsigned IDX_W    = $clog2(N_STREAMS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic               cfg_tt_i,
  input  logic [LEN_W-1:0]   cfg_maxlen_i,
  input  logic [SHARE_W-1:0] cfg_share_i,
  input  logic [BAG_W-1:0]   cfg_bag_i,
  input  logic [JIT_W-1:0]   cfg_jit_i,
  output logic               cfg_err_o,
  input  logic               frm_vld_i,
  input  logic [IDX_W-1:0]   frm_idx_i,
  input  logic [LEN_W-1:0]   frm_len_i,
  input  logic               frm_crit_i,
  input  logic [TS_W-1:0]    now_us_i,
  output logic               vrd_vld_o,
  output logic               vrd_acc_o,
  output logic [SHARE_W-1:0] vrd_share_o,
  output logic               vrd_tt_o
);
  logic            cfg_ok, acc, upd;
  crit_entry_t     cfg_entry, rd_entry;
  logic            rd_cfgd, rd_seen;
  logic [TS_W-1:0] rd_last;

  crit_pol_cfg_chk #(.BAG_W(BAG_W), .JIT_W(JIT_W)) u_cfg_chk (
    .tt_i(cfg_tt_i), .maxlen_i(cfg_maxlen_i), .share_i(cfg_share_i),
    .bag_i(cfg_bag_i), .jit_i(cfg_jit_i), .ok_o(cfg_ok), .entry_o(cfg_entry)
  );

  crit_pol_table #(.N_STREAMS(N_STREAMS), .TS_W(TS_W)) u_table (
    .clk_i, .rst_ni,
    .wr_en_i(cfg_we_i && cfg_ok), .wr_idx_i(cfg_idx_i), .wr_entry_i(cfg_entry),
    .upd_en_i(frm_vld_i && upd), .upd_idx_i(frm_idx_i), .upd_ts_i(now_us_i),
    .rd_idx_i(frm_idx_i), .rd_entry_o(rd_entry), .rd_cfgd_o(rd_cfgd),
    .rd_seen_o(rd_seen), .rd_last_o(rd_last)
  );

  crit_pol_judge #(.TS_W(TS_W)) u_judge (
    .crit_i(frm_crit_i), .len_i(frm_len_i), .entry_i(rd_entry),
    .cfgd_i(rd_cfgd), .seen_i(rd_seen), .last_i(rd_last), .now_i(now_us_i),
    .acc_o(acc), .upd_o(upd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_err_o   <= 1'b0;
      vrd_vld_o   <= 1'b0;
      vrd_acc_o   <= 1'b0;
      vrd_share_o <= '0;
      vrd_tt_o    <= 1'b0;
    end else begin
      cfg_err_o <= cfg_we_i && !cfg_ok;
      vrd_vld_o <= frm_vld_i;
      vrd_acc_o <= frm_vld_i && acc;
      if (frm_vld_i) begin
        vrd_share_o <= rd_entry.share;
        vrd_tt_o    <= rd_entry.tt;
      end
    end
  end
endmodule

// File: rtl/crit_gap_policer_chk.sv
module crit_gap_policer_chk #(
  parameter int unsigned BAG_W = 8,
  parameter int unsigned JIT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [BAG_W-1:0] cfg_bag_i,
  input logic [JIT_W-1:0] cfg_jit_i,
  input logic [11:0]      cfg_maxlen_i,
  input logic             cfg_err_o,
  input logic             frm_vld_i,
  input logic [11:0]      frm_len_i,
  input logic             frm_crit_i,
  input logic             vrd_vld_o,
  input logic             vrd_acc_o
);
  logic bad_cfg;
  assign bad_cfg = (32'(cfg_jit_i) * 32'd10 > 32'(cfg_bag_i) * 32'd100) ||
                   (cfg_maxlen_i > 12'd2043);

  p_vld_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_i |=> vrd_vld_o);
  p_vld_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_vld_i |=> !vrd_vld_o);
  p_acc_needs_vld_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vrd_acc_o |-> vrd_vld_o);
  p_bad_cfg_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && bad_cfg) |=> cfg_err_o);
  p_no_err_without_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> !cfg_err_o);
  p_overlength_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && frm_crit_i && frm_len_i > 12'd2043) |=> !vrd_acc_o);
  p_noncrit_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && !frm_crit_i) |=> vrd_acc_o);
endmodule

bind crit_gap_policer crit_gap_policer_chk #(.BAG_W(BAG_W), .JIT_W(JIT_W)) u_chk (
  .clk_i, .rst_ni, .cfg_we_i, .cfg_bag_i, .cfg_jit_i, .cfg_maxlen_i, .cfg_err_o,
  .frm_vld_i, .frm_len_i, .frm_crit_i, .vrd_vld_o, .vrd_acc_o
);

// File: tb/crit_gap_policer_tb.sv
module crit_gap_policer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_tt = 1'b0;
  logic [3:0]  cfg_idx = '0, cfg_share = '0;
  logic [11:0] cfg_maxlen = '0, cfg_jit = '0;
  logic [7:0]  cfg_bag = '0;
  logic        cfg_err;
  logic        frm_vld = 1'b0, frm_crit = 1'b0;
  logic [3:0]  frm_idx = '0;
  logic [11:0] frm_len = '0;
  logic [31:0] now_us = '0;
  logic        vrd_vld, vrd_acc, vrd_tt;
  logic [3:0]  vrd_share;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  crit_gap_policer u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_tt_i(cfg_tt),
    .cfg_maxlen_i(cfg_maxlen), .cfg_share_i(cfg_share), .cfg_bag_i(cfg_bag),
    .cfg_jit_i(cfg_jit), .cfg_err_o(cfg_err),
    .frm_vld_i(frm_vld), .frm_idx_i(frm_idx), .frm_len_i(frm_len),
    .frm_crit_i(frm_crit), .now_us_i(now_us),
    .vrd_vld_o(vrd_vld), .vrd_acc_o(vrd_acc), .vrd_share_o(vrd_share),
    .vrd_tt_o(vrd_tt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] idx, input logic tt, input logic [11:0] ml,
                     input logic [3:0] sh, input logic [7:0] bag, input logic [11:0] jit,
                     input logic exp_err, input string req);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_tt = tt; cfg_maxlen = ml;
    cfg_share = sh; cfg_bag = bag; cfg_jit = jit;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(req, 32'(cfg_err), 32'(exp_err));
  endtask

  task automatic frame(input logic [3:0] idx, input logic [11:0] len, input logic crit,
                       input logic [31:0] t, input logic exp_acc, input string req);
    @(negedge clk);
    frm_vld = 1'b1; frm_idx = idx; frm_len = len; frm_crit = crit; now_us = t;
    @(negedge clk);
    frm_vld = 1'b0;
    chk({req, " vld"}, 32'(vrd_vld), 32'd1);
    chk(req, 32'(vrd_acc), 32'(exp_acc));
  endtask

  task automatic t_reset();
    chk("R1 reset vld", 32'(vrd_vld), 0);
    chk("R1 reset acc", 32'(vrd_acc), 0);
    chk("R1 reset err", 32'(cfg_err), 0);
  endtask

  task automatic t_unconfigured();
    frame(4'd3, 12'd64, 1'b1, 32'd10, 1'b0, "R8 unconfigured drop");
    chk("R10 unconfigured share", 32'(vrd_share), 0);
    @(negedge clk);
    chk("R1 vld single pulse", 32'(vrd_vld), 0);
  endtask

  task automatic t_gap();
    cfg(4'd1, 1'b1, 12'd1500, 4'd6, 8'd5, 12'd20, 1'b0, "R2 good cfg");
    frame(4'd1, 12'd100, 1'b1, 32'd1000, 1'b1, "R3 first frame");
    chk("R10 share", 32'(vrd_share), 32'd6);
    chk("R10 tt", 32'(vrd_tt), 32'd1);
    frame(4'd1, 12'd100, 1'b1, 32'd1299, 1'b0, "R4 one below gap");
    frame(4'd1, 12'd100, 1'b1, 32'd1300, 1'b1, "R6 R4 exact gap after drop");
  endtask

  task automatic t_length();
    frame(4'd1, 12'd1501, 1'b1, 32'd2000, 1'b0, "R5 over limit");
    frame(4'd1, 12'd1500, 1'b1, 32'd2000, 1'b1, "R5 R6 at limit");
  endtask

  task automatic t_bad_cfg();
    cfg(4'd2, 1'b1, 12'd1000, 4'd3, 8'd5, 12'd51, 1'b1, "R2 jitter too big");
    cfg(4'd7, 1'b0, 12'd2044, 4'd3, 8'd5, 12'd0, 1'b1, "R2 maxlen too big");
    frame(4'd2, 12'd64, 1'b1, 32'd3000, 1'b0, "R2 rejected leaves unconfigured");
    chk("R2 R10 rejected share", 32'(vrd_share), 0);
    cfg(4'd4, 1'b0, 12'd2043, 4'd9, 8'd5, 12'd50, 1'b0, "R2 jitter equals bag");
    frame(4'd4, 12'd2043, 1'b1, 32'd3000, 1'b1, "R5 2043 at limit");
    chk("R10 tt clear", 32'(vrd_tt), 0);
    frame(4'd4, 12'd64, 1'b1, 32'd3000, 1'b1, "R4 zero gap");
    frame(4'd4, 12'd2044, 1'b1, 32'd9000, 1'b0, "R5 over 2043");
  endtask

  task automatic t_noncrit();
    frame(4'd1, 12'd4000, 1'b0, 32'd2001, 1'b1, "R9 noncritical passes");
    frame(4'd1, 12'd100, 1'b1, 32'd2299, 1'b0, "R9 state unchanged");
    frame(4'd3, 12'd100, 1'b0, 32'd0, 1'b1, "R9 unconfigured noncritical");
  endtask

  task automatic t_wrap();
    cfg(4'd5, 1'b0, 12'd500, 4'd1, 8'd1, 12'd0, 1'b0, "R2 cfg wrap stream");
    frame(4'd5, 12'd64, 1'b1, 32'hFFFF_FFC0, 1'b1, "R7 before wrap");
    frame(4'd5, 12'd64, 1'b1, 32'h0000_0020, 1'b0, "R7 wrapped short");
    frame(4'd5, 12'd64, 1'b1, 32'h0000_0024, 1'b1, "R7 wrapped exact");
  endtask

  task automatic t_indep();
    cfg(4'd6, 1'b0, 12'd500, 4'd2, 8'd5, 12'd0, 1'b0, "R2 cfg stream 6");
    frame(4'd6, 12'd64, 1'b1, 32'd5000, 1'b1, "R11 stream 6 first");
    frame(4'd1, 12'd64, 1'b1, 32'd5000, 1'b1, "R11 stream 1 unaffected");
    frame(4'd6, 12'd64, 1'b1, 32'd5100, 1'b0, "R11 stream 6 gap");
  endtask

  task automatic t_reconfig();
    cfg(4'd6, 1'b0, 12'd500, 4'd2, 8'd5, 12'd0, 1'b0, "R2 reconfig");
    frame(4'd6, 12'd64, 1'b1, 32'd5101, 1'b1, "R3 history cleared");
  endtask

  task automatic t_same_cycle();
    // frame judged on old entry (stream 6 last 5101, gap 500); write clears history
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd6; cfg_tt = 1'b1; cfg_maxlen = 12'd500;
    cfg_share = 4'd8; cfg_bag = 8'd5; cfg_jit = 12'd0;
    frm_vld = 1'b1; frm_idx = 4'd6; frm_len = 12'd64; frm_crit = 1'b1; now_us = 32'd5200;
    @(negedge clk);
    cfg_we = 1'b0; frm_vld = 1'b0;
    chk("R12 judged on old entry", 32'(vrd_acc), 0);
    chk("R12 old share", 32'(vrd_share), 32'd2);
    frame(4'd6, 12'd64, 1'b1, 32'd5201, 1'b1, "R12 write wins");
    chk("R12 new share", 32'(vrd_share), 32'd8);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unconfigured();
    t_gap();
    t_length();
    t_bad_cfg();
    t_noncrit();
    t_wrap();
    t_indep();
    t_reconfig();
    t_same_cycle();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule